// File: doc/BRIEF.md
# Power Management Wake Signaling Controller

This block decides when a network controller raises its active-low power-management event output and its legacy wake pin. It keeps the power state, the event enable and a sticky event status bit. Software changes them through a write port laid out like a power control/status register. Three pulsed wake sources feed the status bit: magic packet, link-up and wake frame. The status bit is set by a qualified wake event and cleared only by writing 1 to it.

The event output is gated by four conditions: a device-level wake enable, the event enable bit, the status bit, and one bit of a five-bit support mask. The support mask has one bit for each of D0, D1, D2 and D3hot, plus one bit for the isolation (D3cold) condition. The mask arrives as an input from a loader, so whether the block may signal from D0 is configurable.

The block also gates the IO, memory and boot-ROM decode spaces by power state. It drives a legacy wake pin in one of two modes.

Top module: `pm_wake_ctrl`

## Requirements
- R1: `pme_n` stays 1 whenever `dev_wake_en` is 0 or the event enable (write/readback bit 8) is 0.
- R2: `pme_n` is 0 exactly when status, event enable, `dev_wake_en` and the selected mask bit are all 1. While `isolate_n` is 0 the selected bit is `pme_support[4]`; otherwise it is `pme_support[state]`, with D0=0, D1=1, D2=2 and D3hot=3. A cleared `pme_support[0]` therefore blocks signalling from D0.
- R3: The status bit (readback bit 15) is set at the clock edge where any `wake_evt` bit is 1 while event enable and `dev_wake_en` are both 1. `wake_evt` bit 0 is magic packet, bit 1 is link-up and bit 2 is wake frame. Once set, the status bit holds until it is cleared.
- R4: A write with `cfg_wdata[15]`=1 clears the status bit. A write with bit 15 = 0 leaves it unchanged. A qualified wake event in the same cycle wins, and the status bit ends set.
- R5: `space_en` equals `space_req` in D0 and is all zero in D1, D2 and D3hot. Bit 0 of each is IO, bit 1 is memory and bit 2 is boot ROM.
- R6: A synchronous reset (`rst_n`=0 at a clock edge) returns the power state to D0, including from D3hot with `isolate_n` low (D3cold). It also clears event enable and status, so `cfg_rdata` reads 0.
- R7: A write loads the power state from `cfg_wdata[1:0]` and event enable from `cfg_wdata[8]`. Both are visible on `cfg_rdata` (same bit positions, other bits 0) and take effect on all outputs in the cycle after the write edge, with no further delay.
- R8: `lwake` is 0 whenever `lw_en` is 0.
- R9: With `lw_en`=1 and `lw_mode`=1, `lwake` is 1 exactly when `pme_n` is 0 and `isolate_n` is 0.
- R10: With `lw_en`=1 and `lw_mode`=0, `lwake` is 1 in the same cycle as any `wake_evt` bit, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the power control/status word |
| cfg_wdata | input | 16 | Write data: bit 15 status clear, bit 8 event enable, bits 1:0 state |
| cfg_rdata | output | 16 | Readback of status, event enable and state |
| wake_evt | input | 3 | Wake event pulses: magic packet, link-up, wake frame |
| dev_wake_en | input | 1 | Device-level wake enable |
| pme_support | input | 5 | Support mask: D0, D1, D2, D3hot, isolation |
| isolate_n | input | 1 | Low while the device is isolated (D3cold) |
| space_req | input | 3 | Requested IO, memory and boot-ROM decode enables |
| space_en | output | 3 | Effective decode enables |
| lw_en | input | 1 | Legacy wake pin enable |
| lw_mode | input | 1 | 1: follow the event output while isolated; 0: any wake event |
| pme_n | output | 1 | Active-low power-management event |
| lwake | output | 1 | Legacy wake output |

## Verification
Two functions can fall in the same cycle: software clearing the status bit by writing 1, and a new qualified wake event setting it. The bench provokes this by presenting a wake-frame pulse together with a clearing write at one clock edge. It judges the result by the readback status and `pme_n` afterwards: the event must not be lost, so status must read 1 and `pme_n` must be 0. A following write of 1 with no event must then clear status and release `pme_n`.

// File: rtl/pm_wake_pkg.sv
// Package: shared widths, bit positions and the power-state type for the
// wake signaling controller. Assumes a 16-bit control/status word.
package pm_wake_pkg;
    localparam int CSR_W     = 16;
    localparam int STAT_BIT  = 15;
    localparam int PMEEN_BIT = 8;
    localparam int ST_W      = 2;
    localparam int N_EVT     = 3;
    localparam int N_MASK    = 5;
    localparam int ISO_IDX   = N_MASK - 1;
    localparam int N_SPACE   = 3;

    typedef enum logic [ST_W-1:0] {
        PS_D0    = 2'd0,
        PS_D1    = 2'd1,
        PS_D2    = 2'd2,
        PS_D3HOT = 2'd3
    } pstate_e;
endpackage

// File: rtl/pm_csr.sv
// pm_csr: holds power state, event enable and the sticky status bit.
// Assumes evt_qual is already qualified by the enables; a qualified event
// beats a write-one-to-clear in the same cycle.
module pm_csr
    import pm_wake_pkg::*;
#(
    parameter int W = CSR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic [W-1:0] cfg_wdata,
    input  logic         evt_qual,
    output pstate_e      state,
    output logic         pme_en,
    output logic         status
);
    // Power state and event enable: reset to D0/off, loaded by writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= PS_D0;
            pme_en <= 1'b0;
        end else if (cfg_wr) begin
            state  <= pstate_e'(cfg_wdata[ST_W-1:0]);
            pme_en <= cfg_wdata[PMEEN_BIT];
        end
    end

    // Sticky status: set by a qualified event, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (evt_qual) begin
            status <= 1'b1;
        end else if (cfg_wr && cfg_wdata[STAT_BIT]) begin
            status <= 1'b0;
        end
    end
endmodule

// File: rtl/pm_evt_gate.sv
// pm_evt_gate: qualifies wake events, selects the support-mask bit for the
// current state (isolation overrides), drives the active-low event output
// and gates the decode-space enables. Purely combinational.
module pm_evt_gate
    import pm_wake_pkg::*;
#(
    parameter int NE = N_EVT,
    parameter int NM = N_MASK,
    parameter int NS = N_SPACE
) (
    input  pstate_e        state,
    input  logic           pme_en,
    input  logic           status,
    input  logic           dev_wake_en,
    input  logic           isolate_n,
    input  logic [NE-1:0]  wake_evt,
    input  logic [NM-1:0]  pme_support,
    input  logic [NS-1:0]  space_req,
    output logic           any_evt,
    output logic           evt_qual,
    output logic           pme_n,
    output logic [NS-1:0]  space_en
);
    localparam int IDX_W = $clog2(NM);

    logic [IDX_W-1:0] sel;
    logic             in_d0;

    // Event qualification: any source counts while both enables are on.
    always_comb begin
        any_evt  = |wake_evt;
        evt_qual = any_evt && pme_en && dev_wake_en;
    end

    // Mask select and event output: isolation uses the top mask bit.
    always_comb begin
        sel   = isolate_n ? IDX_W'(state) : IDX_W'(NM - 1);
        pme_n = !(status && pme_en && dev_wake_en && pme_support[sel]);
        in_d0 = (state == PS_D0);
    end

    // One gate per decode space: only D0 passes the request through.
    for (genvar g = 0; g < NS; g++) begin : g_space
        assign space_en[g] = space_req[g] && in_d0;
    end
endmodule

// File: rtl/pm_lwake.sv
// pm_lwake: legacy wake pin. Mode 1 follows the event output while the
// device is isolated; mode 0 pulses on any wake event. Combinational.
module pm_lwake (
    input  logic lw_en,
    input  logic lw_mode,
    input  logic pme_n,
    input  logic isolate_n,
    input  logic any_evt,
    output logic lwake
);
    // Mode select and master enable.
    always_comb begin
        if (!lw_en)       lwake = 1'b0;
        else if (lw_mode) lwake = !pme_n && !isolate_n;
        else              lwake = any_evt;
    end
endmodule

// File: rtl/pm_wake_ctrl.sv
// pm_wake_ctrl: top of the wake signaling controller. Connects the register
// bank, event gate and legacy wake logic and forms the readback word.
// Assumes wake_evt bits are single-cycle pulses synchronous to clk.
module pm_wake_ctrl
    import pm_wake_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [CSR_W-1:0]     cfg_wdata,
    output logic [CSR_W-1:0]     cfg_rdata,
    input  logic [N_EVT-1:0]     wake_evt,
    input  logic                 dev_wake_en,
    input  logic [N_MASK-1:0]    pme_support,
    input  logic                 isolate_n,
    input  logic [N_SPACE-1:0]   space_req,
    output logic [N_SPACE-1:0]   space_en,
    input  logic                 lw_en,
    input  logic                 lw_mode,
    output logic                 pme_n,
    output logic                 lwake
);
    pstate_e state;
    logic    pme_en, status, any_evt, evt_qual;

    pm_csr #(.W(CSR_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .evt_qual(evt_qual), .state(state), .pme_en(pme_en), .status(status)
    );

    pm_evt_gate #(.NE(N_EVT), .NM(N_MASK), .NS(N_SPACE)) u_gate (
        .state(state), .pme_en(pme_en), .status(status),
        .dev_wake_en(dev_wake_en), .isolate_n(isolate_n),
        .wake_evt(wake_evt), .pme_support(pme_support),
        .space_req(space_req), .any_evt(any_evt), .evt_qual(evt_qual),
        .pme_n(pme_n), .space_en(space_en)
    );

    pm_lwake u_lw (
        .lw_en(lw_en), .lw_mode(lw_mode), .pme_n(pme_n),
        .isolate_n(isolate_n), .any_evt(any_evt), .lwake(lwake)
    );

    // Readback word: status, event enable and state at their positions.
    always_comb begin
        cfg_rdata            = '0;
        cfg_rdata[STAT_BIT]  = status;
        cfg_rdata[PMEEN_BIT] = pme_en;
        cfg_rdata[ST_W-1:0]  = state;
    end
endmodule

// File: rtl/pm_wake_chk.sv
// pm_wake_chk: assertion checker bound to pm_wake_ctrl; observes ports only.
module pm_wake_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [15:0] cfg_wdata,
    input logic [15:0] cfg_rdata,
    input logic [2:0]  wake_evt,
    input logic        dev_wake_en,
    input logic        isolate_n,
    input logic [2:0]  space_en,
    input logic        lw_en,
    input logic        lw_mode,
    input logic        pme_n,
    input logic        lwake
);
    a_r1_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[8] || !dev_wake_en) |-> pme_n);

    a_r3_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[15] && !(cfg_wr && cfg_wdata[15])) |=> cfg_rdata[15]);

    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[15] && wake_evt == 3'b000) |=> !cfg_rdata[15]);

    a_r5_spaces_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[1:0] != 2'd0) |-> (space_en == 3'b000));

    a_r6_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cfg_rdata == 16'h0000));

    a_r8_lw_off: assert property (@(posedge clk) disable iff (!rst_n)
        !lw_en |-> !lwake);

    a_r9_lw_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (lw_en && lw_mode && (pme_n || isolate_n)) |-> !lwake);

    a_r10_lw_any: assert property (@(posedge clk) disable iff (!rst_n)
        (lw_en && !lw_mode && wake_evt != 3'b000) |-> lwake);
endmodule

bind pm_wake_ctrl pm_wake_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wake_evt(wake_evt), .dev_wake_en(dev_wake_en),
    .isolate_n(isolate_n), .space_en(space_en), .lw_en(lw_en),
    .lw_mode(lw_mode), .pme_n(pme_n), .lwake(lwake)
);

// File: tb/pm_wake_ctrl_bench.sv
// Directed bench for pm_wake_ctrl: one task per scenario, each self-checking.
module pm_wake_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [2:0]  wake_evt = '0;
    logic        dev_wake_en = 1'b0;
    logic [4:0]  pme_support = '0;
    logic        isolate_n = 1'b1;
    logic [2:0]  space_req = '0;
    logic [2:0]  space_en;
    logic        lw_en = 1'b0;
    logic        lw_mode = 1'b0;
    logic        pme_n, lwake;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    pm_wake_ctrl u_pm_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .wake_evt(wake_evt), .dev_wake_en(dev_wake_en),
        .pme_support(pme_support), .isolate_n(isolate_n),
        .space_req(space_req), .space_en(space_en), .lw_en(lw_en),
        .lw_mode(lw_mode), .pme_n(pme_n), .lwake(lwake)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [15:0] d);
        cfg_wr = 1'b1; cfg_wdata = d;
        tick();
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic pulse(logic [2:0] e);
        wake_evt = e;
        tick();
        wake_evt = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
        space_req = 3'b111; #1;
        chk("R6 readback after reset", cfg_rdata, 16'h0000);
        chk("R6 pme_n after reset", pme_n, 1);
        chk("R5 spaces in D0", space_en, 3'b111);
        chk("R8 lwake after reset", lwake, 0);
    endtask

    task automatic t_gate();
        dev_wake_en = 1'b1; pme_support = 5'b11111;
        pulse(3'b001);
        chk("R1 event ignored with enable off", cfg_rdata[15], 0);
        chk("R1 pme_n with enable off", pme_n, 1);
        wr(16'h0100);
        chk("R7 enable visible", cfg_rdata, 16'h0100);
        pulse(3'b010);
        chk("R3 link-up sets status", cfg_rdata[15], 1);
        chk("R2 pme_n asserted", pme_n, 0);
        dev_wake_en = 1'b0; #1;
        chk("R1 device enable off", pme_n, 1);
        dev_wake_en = 1'b1; #1;
        tick();
        chk("R3 status holds", cfg_rdata[15], 1);
    endtask

    task automatic t_w1c();
        wr(16'h0100);
        chk("R4 write zero keeps status", cfg_rdata[15], 1);
        wr(16'h8100);
        chk("R4 write one clears status", cfg_rdata[15], 0);
        chk("R4 pme_n released", pme_n, 1);
    endtask

    task automatic t_collide();
        wake_evt = 3'b100;
        wr(16'h8100);
        wake_evt = '0;
        chk("R4 event wins over clear", cfg_rdata[15], 1);
        chk("R4 pme_n after collision", pme_n, 0);
        wr(16'h8100);
        chk("R4 clear after collision", cfg_rdata[15], 0);
    endtask

    task automatic t_mask();
        pme_support = 5'b11110;
        pulse(3'b001);
        chk("R2 D0 masked status set", cfg_rdata[15], 1);
        chk("R2 D0 masked pme_n", pme_n, 1);
        wr(16'h0103);
        chk("R7 state D3hot", cfg_rdata[1:0], 3);
        chk("R2 D3hot allowed", pme_n, 0);
        chk("R5 spaces off in D3hot", space_en, 3'b000);
        pme_support = 5'b00111; #1;
        chk("R2 D3hot masked", pme_n, 1);
        isolate_n = 1'b0; #1;
        chk("R2 isolation bit clear", pme_n, 1);
        pme_support = 5'b10111; #1;
        chk("R2 isolation bit set", pme_n, 0);
    endtask

    task automatic t_lwake();
        lw_en = 1'b0; lw_mode = 1'b1; #1;
        chk("R8 disabled pin", lwake, 0);
        lw_en = 1'b1; #1;
        chk("R9 follow while isolated", lwake, 1);
        isolate_n = 1'b1; #1;
        chk("R9 not isolated", lwake, 0);
        lw_mode = 1'b0; #1;
        chk("R10 no event", lwake, 0);
        wake_evt = 3'b010; #1;
        chk("R10 event same cycle", lwake, 1);
        lw_en = 1'b0; #1;
        chk("R8 disabled with event", lwake, 0);
        wake_evt = '0; #1;
    endtask

    task automatic t_states();
        wr(16'h0102);
        chk("R5 spaces off in D2", space_en, 3'b000);
        chk("R7 state D2", cfg_rdata[1:0], 2);
        space_req = 3'b101;
        wr(16'h0100);
        chk("R5 spaces back in D0", space_en, 3'b101);
    endtask

    task automatic t_d3cold_reset();
        wr(16'h0103);
        isolate_n = 1'b0;
        pulse(3'b001);
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        chk("R6 D3cold returns to D0", cfg_rdata, 16'h0000);
        isolate_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_gate();
        t_w1c();
        t_collide();
        t_mask();
        t_lwake();
        t_states();
        t_d3cold_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule